// File: doc/BRIEF.md
# Tile Buffer Spill and Reload Sequencer

This block steps a small on-chip tile buffer through the life of one render batch. The buffer holds a 32-bit color word and a 32-bit depth word for each pixel of a 16x16 tile. The buffer RAM sits outside the block. The sequencer drives that RAM's write port and read address. Each batch first fills the tile with fixed clear values. It then restores the color and depth saved by the previous batch from backing memory, and hands the tile to the rasterizer. Once the rasterizer reports the primitive complete, the sequencer streams all color words out and then all depth words, one word per cycle, on two separate emit streams.

Depth therefore survives from one batch to the next only through this spill and reload round trip. After reset no saved image exists yet, so the first batch skips the reload and renders over the cleared tile. A batch-valid flag is set once a spill completes and is cleared by reset. That flag decides whether a batch reloads. The caller starts a batch with a pulse and receives a done pulse when the last depth word leaves.

Top module: `tile_spill_seq`

## Requirements
- R1: While reset is held and right after it, `phase` is 0 (idle). `batchDone`, `reloadStart`, both tile write enables and both emit outputs are low.
- R2: `phase` encodes idle=0, clear=1, render=2, color spill=3, reload=5 and depth spill=6. A batch runs clear, then reload (when done at all), then render, then color spill, then depth spill, and returns to idle.
- R3: Clear takes 256 consecutive cycles. Each cycle raises both tile write enables, with addresses 0 to 255 in order, color data 0xFF008000 and depth data 0x00004000.
- R4: The first batch after reset has no reload phase and no `reloadStart` pulse.
- R5: Every later batch reloads, and `reloadStart` is high for exactly the first reload cycle. The backing memory returns data one cycle after an address is presented. When `reloadReady` is high, that data is written to the tile entry at that address. While `reloadReady` is low nothing is written and the same address is presented again.
- R6: `renderEn` is high exactly in the render phase. The render phase lasts until `renderDone` is seen high.
- R7: The color spill gives exactly 256 `colorEmit` cycles per batch, tile entries 0 to 255 in order. Each carries the tile color read on the cycle before.
- R8: The depth spill gives exactly 256 `depthEmit` cycles per batch, entries 0 to 255 in order, each carrying the tile depth read on the cycle before.
- R9: Tile index bits [7:4] are y and bits [3:0] are x. Each emitted address is the byte address 4*(64*y + x), so bits [12:2] hold the screen word index and bits [1:0] are zero.
- R10: `batchDone` is a one-cycle pulse. It comes in the cycle of the final depth emit (entry 255), with `phase` already back at idle.
- R11: A `batchStart` pulse outside idle is ignored. The running batch keeps its phase and still spills all 256 entries of each kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| batchStart | input | 1 | Start pulse for one batch, honoured in idle only |
| renderDone | input | 1 | Rasterizer reports the primitive complete |
| phase | output | 3 | Current phase code |
| renderEn | output | 1 | Tile is handed to the rasterizer |
| batchDone | output | 1 | One-cycle end-of-batch pulse |
| tileWrAddr | output | 8 | Tile RAM write index |
| tileColorWe | output | 1 | Tile color write enable |
| tileDepthWe | output | 1 | Tile depth write enable |
| tileColorWrData | output | 32 | Tile color write data |
| tileDepthWrData | output | 32 | Tile depth write data |
| tileRdAddr | output | 8 | Tile RAM read index (one-cycle read latency) |
| tileColorRdData | input | 32 | Tile color read data |
| tileDepthRdData | input | 32 | Tile depth read data |
| reloadStart | output | 1 | Pulse on the first reload cycle |
| reloadAddr | output | 8 | Tile index requested from backing memory |
| reloadReady | input | 1 | Backing data for the previous address is valid |
| reloadColor | input | 32 | Backing color data |
| reloadDepth | input | 32 | Backing depth data |
| colorEmit | output | 1 | Color spill word valid |
| colorAddr | output | 32 | Color spill byte address |
| colorData | output | 32 | Color spill data |
| depthEmit | output | 1 | Depth spill word valid |
| depthAddr | output | 32 | Depth spill byte address |
| depthData | output | 32 | Depth spill data |

## Verification
The first batch after reset runs against a tile that only the clear and a few rendered pixels touch. Its spill must match clear values with those pixels overlaid, which separates a real clear from a stray reload. A second batch reloads while `reloadReady` drops every third cycle and renders a few new pixels. Its spill must equal the first batch's spill with the new pixels on top, which exposes lost, shifted or unqualified reload writes. A third batch reloads with `reloadReady` held high and renders nothing, so any difference from the previous spill points at the round trip alone. A reset followed by a fourth batch must return to clear-only behaviour, which shows that the batch-valid flag is cleared.

// File: rtl/tile_spill_pkg.sv
package tile_spill_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CLEAR  = 3'd1,
    PH_RENDER = 3'd2,
    PH_CSPILL = 3'd3,
    PH_RELOAD = 3'd5,
    PH_ZSPILL = 3'd6
  } phase_e;

  typedef struct packed {
    logic idxClr;     // restart the tile index walk
    logic clearWr;    // write clear values at the index
    logic reloadRun;  // issue/accept reload traffic
    logic colorRd;    // read color for the color spill
    logic depthRd;    // read depth for the depth spill
  } tile_strobe_t;

endpackage

// File: rtl/tile_spill_ctrl.sv
module tile_spill_ctrl
  import tile_spill_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         batchStart,
  input  logic         renderDone,
  input  logic         idxLast,
  input  logic         reloadLast,
  output phase_e       phaseQ,
  output tile_strobe_t strb,
  output logic         reloadStart,
  output logic         batchDone,
  output logic         renderEn
);

  phase_e phaseNxt;
  logic   batchValid;

  always_comb begin
    phaseNxt = phaseQ;
    strb     = '0;
    case (phaseQ)
      PH_IDLE: begin
        if (batchStart) begin
          phaseNxt    = PH_CLEAR;
          strb.idxClr = 1'b1;
        end
      end
      PH_CLEAR: begin
        strb.clearWr = 1'b1;
        if (idxLast) begin
          strb.idxClr = 1'b1;
          phaseNxt    = batchValid ? PH_RELOAD : PH_RENDER;
        end
      end
      PH_RELOAD: begin
        strb.reloadRun = 1'b1;
        if (reloadLast) begin
          strb.idxClr = 1'b1;
          phaseNxt    = PH_RENDER;
        end
      end
      PH_RENDER: begin
        if (renderDone) begin
          strb.idxClr = 1'b1;
          phaseNxt    = PH_CSPILL;
        end
      end
      PH_CSPILL: begin
        strb.colorRd = 1'b1;
        if (idxLast) begin
          strb.idxClr = 1'b1;
          phaseNxt    = PH_ZSPILL;
        end
      end
      PH_ZSPILL: begin
        strb.depthRd = 1'b1;
        if (idxLast) begin
          strb.idxClr = 1'b1;
          phaseNxt    = PH_IDLE;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ      <= PH_IDLE;
      batchValid  <= 1'b0;
      reloadStart <= 1'b0;
      batchDone   <= 1'b0;
    end else begin
      phaseQ      <= phaseNxt;
      reloadStart <= (phaseQ == PH_CLEAR) && (phaseNxt == PH_RELOAD);
      batchDone   <= (phaseQ == PH_ZSPILL) && (phaseNxt == PH_IDLE);
      if ((phaseQ == PH_ZSPILL) && (phaseNxt == PH_IDLE)) batchValid <= 1'b1;
    end
  end

  assign renderEn = (phaseQ == PH_RENDER);

  // R2: only the six defined codes ever appear
  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ inside {PH_IDLE, PH_CLEAR, PH_RENDER, PH_CSPILL, PH_RELOAD, PH_ZSPILL});

  // R2: clear is followed by reload or render only
  p_clear_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_CLEAR) |=> (phaseQ inside {PH_CLEAR, PH_RELOAD, PH_RENDER}));

  // R2: color spill hands over to depth spill
  p_spill_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_CSPILL) |=> (phaseQ inside {PH_CSPILL, PH_ZSPILL}));

  // R4: without a completed spill there is no reload
  p_boot_skip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!batchValid && phaseQ == PH_CLEAR) |=> (phaseQ != PH_RELOAD));

  // R5: the reload marker sits in reload and lasts one cycle
  p_reload_mark_r5: assert property (@(posedge clk) disable iff (!rstN)
    reloadStart |-> (phaseQ == PH_RELOAD && $past(phaseQ) == PH_CLEAR));
  p_reload_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    reloadStart |=> !reloadStart);

  // R6: render is held until the rasterizer reports completion
  p_render_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_RENDER && !renderDone) |=> (phaseQ == PH_RENDER));

  // R10: done is a single pulse seen in idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    batchDone |-> (phaseQ == PH_IDLE && $past(phaseQ) == PH_ZSPILL));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    batchDone |=> !batchDone);

  // R11: a start pulse in render does not disturb the batch
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_RENDER && batchStart && !renderDone) |=> (phaseQ == PH_RENDER));

endmodule

// File: rtl/tile_spill_lane.sv
module tile_spill_lane #(
  parameter int IDX_W       = 8,
  parameter int TILE_W_LOG2 = 4,
  parameter int ROW_LOG2    = 6,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rdData,
  output logic              emit,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  localparam int BYTE_SHIFT = 2;

  logic [IDX_W-1:0]  idxQ;
  logic [ADDR_W-1:0] wordIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emit <= 1'b0;
      idxQ <= '0;
    end else begin
      emit <= rdEn;
      idxQ <= idx;
    end
  end

  assign wordIdx = (ADDR_W'(idxQ[IDX_W-1:TILE_W_LOG2]) << ROW_LOG2)
                 | ADDR_W'(idxQ[TILE_W_LOG2-1:0]);
  assign addr    = wordIdx << BYTE_SHIFT;
  assign data    = rdData;

  // R9: back-to-back emits of one stream never repeat an address
  p_emit_advance_r9: assert property (@(posedge clk) disable iff (!rstN)
    (emit && $past(emit)) |-> (addr != $past(addr)));

endmodule

// File: rtl/tile_spill_dp.sv
module tile_spill_dp
  import tile_spill_pkg::*;
#(
  parameter int              TILE_W_LOG2 = 4,
  parameter int              TILE_H_LOG2 = 4,
  parameter int              ROW_LOG2    = 6,
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 32,
  parameter logic [DATA_W-1:0] CLR_COLOR = 32'hFF00_8000,
  parameter logic [DATA_W-1:0] CLR_DEPTH = 32'h0000_4000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tile_strobe_t           strb,
  output logic                   idxLast,
  output logic                   reloadLast,
  output logic [TILE_W_LOG2+TILE_H_LOG2-1:0] tileWrAddr,
  output logic                   tileColorWe,
  output logic                   tileDepthWe,
  output logic [DATA_W-1:0]      tileColorWrData,
  output logic [DATA_W-1:0]      tileDepthWrData,
  output logic [TILE_W_LOG2+TILE_H_LOG2-1:0] tileRdAddr,
  input  logic [DATA_W-1:0]      tileColorRdData,
  input  logic [DATA_W-1:0]      tileDepthRdData,
  output logic [TILE_W_LOG2+TILE_H_LOG2-1:0] reloadAddr,
  input  logic                   reloadReady,
  input  logic [DATA_W-1:0]      reloadColor,
  input  logic [DATA_W-1:0]      reloadDepth,
  output logic                   colorEmit,
  output logic [ADDR_W-1:0]      colorAddr,
  output logic [DATA_W-1:0]      colorData,
  output logic                   depthEmit,
  output logic [ADDR_W-1:0]      depthAddr,
  output logic [DATA_W-1:0]      depthData
);

  localparam int IDX_W  = TILE_W_LOG2 + TILE_H_LOG2;
  localparam int TILE_N = 1 << IDX_W;
  localparam int LANES  = 2;

  logic [IDX_W:0]   idx;        // one extra bit marks "all addresses issued"
  logic [IDX_W-1:0] lastAddr;   // address the backing memory is answering
  logic             armed;
  logic             stall;
  logic             fire;

  assign stall      = armed && !reloadReady;
  assign fire       = strb.reloadRun && armed && reloadReady;
  assign idxLast    = (idx == (IDX_W+1)'(TILE_N - 1));
  assign reloadLast = fire && (lastAddr == IDX_W'(TILE_N - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      lastAddr <= '0;
      armed    <= 1'b0;
    end else if (strb.idxClr) begin
      idx   <= '0;
      armed <= 1'b0;
    end else if (strb.reloadRun) begin
      if (!stall) begin
        if (!idx[IDX_W]) begin
          lastAddr <= idx[IDX_W-1:0];
          armed    <= 1'b1;
          idx      <= idx + 1'b1;
        end else begin
          armed <= 1'b0;
        end
      end
    end else if (strb.clearWr || strb.colorRd || strb.depthRd) begin
      idx <= idx + 1'b1;
    end
  end

  assign reloadAddr      = stall ? lastAddr : idx[IDX_W-1:0];
  assign tileWrAddr      = strb.clearWr ? idx[IDX_W-1:0] : lastAddr;
  assign tileColorWe     = strb.clearWr || fire;
  assign tileDepthWe     = strb.clearWr || fire;
  assign tileColorWrData = strb.clearWr ? CLR_COLOR : reloadColor;
  assign tileDepthWrData = strb.clearWr ? CLR_DEPTH : reloadDepth;
  assign tileRdAddr      = idx[IDX_W-1:0];

  logic [LANES-1:0] laneRd;
  logic [LANES-1:0] laneEmit;
  logic [DATA_W-1:0] laneIn   [LANES];
  logic [ADDR_W-1:0] laneAddr [LANES];
  logic [DATA_W-1:0] laneData [LANES];

  assign laneRd    = {strb.depthRd, strb.colorRd};
  assign laneIn[0] = tileColorRdData;
  assign laneIn[1] = tileDepthRdData;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    tile_spill_lane #(
      .IDX_W(IDX_W), .TILE_W_LOG2(TILE_W_LOG2), .ROW_LOG2(ROW_LOG2),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_lane (
      .clk(clk), .rstN(rstN), .rdEn(laneRd[gi]), .idx(idx[IDX_W-1:0]),
      .rdData(laneIn[gi]), .emit(laneEmit[gi]), .addr(laneAddr[gi]),
      .data(laneData[gi])
    );
  end

  assign colorEmit = laneEmit[0];
  assign colorAddr = laneAddr[0];
  assign colorData = laneData[0];
  assign depthEmit = laneEmit[1];
  assign depthAddr = laneAddr[1];
  assign depthData = laneData[1];

  // R3: clear writes walk the tile one entry per cycle
  p_clear_walk_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearWr && $past(strb.clearWr) && !$past(strb.idxClr))
      |-> (tileWrAddr == $past(tileWrAddr) + 1'b1));

  // R5: during a stall the previously presented address is repeated
  p_stall_repeat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reloadRun && stall) |-> (reloadAddr == $past(reloadAddr)));

  // R5: no tile write without ready while reloading
  p_reload_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reloadRun && !reloadReady) |-> !tileDepthWe);

endmodule

// File: rtl/tile_spill_seq.sv
module tile_spill_seq
  import tile_spill_pkg::*;
#(
  parameter int              TILE_W_LOG2 = 4,
  parameter int              TILE_H_LOG2 = 4,
  parameter int              ROW_LOG2    = 6,
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 32,
  parameter logic [DATA_W-1:0] CLR_COLOR = 32'hFF00_8000,
  parameter logic [DATA_W-1:0] CLR_DEPTH = 32'h0000_4000,
  localparam int             IDX_W       = TILE_W_LOG2 + TILE_H_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              batchStart,
  input  logic              renderDone,
  output logic [2:0]        phase,
  output logic              renderEn,
  output logic              batchDone,
  output logic [IDX_W-1:0]  tileWrAddr,
  output logic              tileColorWe,
  output logic              tileDepthWe,
  output logic [DATA_W-1:0] tileColorWrData,
  output logic [DATA_W-1:0] tileDepthWrData,
  output logic [IDX_W-1:0]  tileRdAddr,
  input  logic [DATA_W-1:0] tileColorRdData,
  input  logic [DATA_W-1:0] tileDepthRdData,
  output logic              reloadStart,
  output logic [IDX_W-1:0]  reloadAddr,
  input  logic              reloadReady,
  input  logic [DATA_W-1:0] reloadColor,
  input  logic [DATA_W-1:0] reloadDepth,
  output logic              colorEmit,
  output logic [ADDR_W-1:0] colorAddr,
  output logic [DATA_W-1:0] colorData,
  output logic              depthEmit,
  output logic [ADDR_W-1:0] depthAddr,
  output logic [DATA_W-1:0] depthData
);

  phase_e       phaseQ;
  tile_strobe_t strb;
  logic         idxLast;
  logic         reloadLast;

  tile_spill_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .batchStart(batchStart), .renderDone(renderDone),
    .idxLast(idxLast), .reloadLast(reloadLast), .phaseQ(phaseQ), .strb(strb),
    .reloadStart(reloadStart), .batchDone(batchDone), .renderEn(renderEn)
  );

  tile_spill_dp #(
    .TILE_W_LOG2(TILE_W_LOG2), .TILE_H_LOG2(TILE_H_LOG2), .ROW_LOG2(ROW_LOG2),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLR_COLOR(CLR_COLOR), .CLR_DEPTH(CLR_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idxLast(idxLast), .reloadLast(reloadLast),
    .tileWrAddr(tileWrAddr), .tileColorWe(tileColorWe), .tileDepthWe(tileDepthWe),
    .tileColorWrData(tileColorWrData), .tileDepthWrData(tileDepthWrData),
    .tileRdAddr(tileRdAddr), .tileColorRdData(tileColorRdData),
    .tileDepthRdData(tileDepthRdData), .reloadAddr(reloadAddr),
    .reloadReady(reloadReady), .reloadColor(reloadColor), .reloadDepth(reloadDepth),
    .colorEmit(colorEmit), .colorAddr(colorAddr), .colorData(colorData),
    .depthEmit(depthEmit), .depthAddr(depthAddr), .depthData(depthData)
  );

  assign phase = phaseQ;

  // R1: nothing is written or emitted while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_IDLE && $past(phaseQ) == PH_IDLE) |-> (!tileColorWe && !colorEmit && !depthEmit));

endmodule

// File: tb/tile_spill_seq_tb.sv
`timescale 1ns/1ps
module tile_spill_seq_tb;

  localparam logic [31:0] CLR_C = 32'hFF00_8000;
  localparam logic [31:0] CLR_Z = 32'h0000_4000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, batchStart, renderDone;
  logic [2:0]  phase;
  logic        renderEn, batchDone;
  logic [7:0]  tileWrAddr, tileRdAddr, reloadAddr;
  logic        tileColorWe, tileDepthWe, reloadStart, reloadReady;
  logic [31:0] tileColorWrData, tileDepthWrData, tileColorRdData, tileDepthRdData;
  logic [31:0] reloadColor, reloadDepth;
  logic        colorEmit, depthEmit;
  logic [31:0] colorAddr, colorData, depthAddr, depthData;

  tile_spill_seq u_dut (
    .clk(clk), .rstN(rstN), .batchStart(batchStart), .renderDone(renderDone),
    .phase(phase), .renderEn(renderEn), .batchDone(batchDone),
    .tileWrAddr(tileWrAddr), .tileColorWe(tileColorWe), .tileDepthWe(tileDepthWe),
    .tileColorWrData(tileColorWrData), .tileDepthWrData(tileDepthWrData),
    .tileRdAddr(tileRdAddr), .tileColorRdData(tileColorRdData),
    .tileDepthRdData(tileDepthRdData), .reloadStart(reloadStart),
    .reloadAddr(reloadAddr), .reloadReady(reloadReady), .reloadColor(reloadColor),
    .reloadDepth(reloadDepth), .colorEmit(colorEmit), .colorAddr(colorAddr),
    .colorData(colorData), .depthEmit(depthEmit), .depthAddr(depthAddr),
    .depthData(depthData)
  );

  // ---------------- tile RAM and rasterizer write port ----------------
  logic [31:0] ramC [256];
  logic [31:0] ramZ [256];
  logic        rastWe;
  logic [7:0]  rastIdx;
  logic [31:0] rastC, rastZ;

  always @(posedge clk) begin
    if (tileColorWe) ramC[tileWrAddr] <= tileColorWrData;
    if (tileDepthWe) ramZ[tileWrAddr] <= tileDepthWrData;
    if (rastWe) begin
      ramC[rastIdx] <= rastC;
      ramZ[rastIdx] <= rastZ;
    end
    tileColorRdData <= ramC[tileRdAddr];
    tileDepthRdData <= ramZ[tileRdAddr];
  end

  // ---------------- backing memory, filled from the spill streams ----------------
  logic [31:0] bkC [256];
  logic [31:0] bkZ [256];
  logic [7:0]  bkRa;
  int          cyc;
  int          readyMode;

  always @(posedge clk) begin
    if (colorEmit) bkC[{colorAddr[11:8], colorAddr[5:2]}] <= colorData;
    if (depthEmit) bkZ[{depthAddr[11:8], depthAddr[5:2]}] <= depthData;
    bkRa <= reloadAddr;
    cyc  <= cyc + 1;
  end
  assign reloadColor = bkC[bkRa];
  assign reloadDepth = bkZ[bkRa];
  assign reloadReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 0);

  // ---------------- scoreboard ----------------
  int nCmp, nBad;
  logic [63:0] colorQ [$];
  logic [63:0] depthQ [$];
  logic [2:0]  traceQ [$];
  logic [2:0]  prevPhase;
  int cEm, zEm, clrSeen, clrBad, rlStarts, rlNoReady, doneBad;
  logic [31:0] expC [256];
  logic [31:0] expZ [256];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input logic [7:0] i);
    return ((32'(i[7:4]) * 64) + 32'(i[3:0])) * 4;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (phase != prevPhase) traceQ.push_back(phase);
      prevPhase = phase;
      if (colorEmit) begin
        cEm++;
        if (colorQ.size() == 0) check(1'b0, "R7 unexpected color emit", 64'(colorAddr), 64'hx);
        else begin
          logic [63:0] e;
          e = colorQ.pop_front();
          check({colorAddr, colorData} == e, "R7/R9 color emit", {colorAddr, colorData}, e);
        end
      end
      if (depthEmit) begin
        zEm++;
        if (depthQ.size() == 0) check(1'b0, "R8 unexpected depth emit", 64'(depthAddr), 64'hx);
        else begin
          logic [63:0] e;
          e = depthQ.pop_front();
          check({depthAddr, depthData} == e, "R8/R9 depth emit", {depthAddr, depthData}, e);
        end
      end
      if (phase == 3'd1 && tileColorWe) begin
        if (tileWrAddr != 8'(clrSeen) || tileColorWrData != CLR_C ||
            tileDepthWrData != CLR_Z || !tileDepthWe) clrBad++;
        clrSeen++;
      end
      if (reloadStart) begin
        rlStarts++;
        if (phase != 3'd5) doneBad++;
      end
      if (phase == 3'd5 && tileDepthWe && !reloadReady) rlNoReady++;
      if (batchDone) begin
        if (phase != 3'd0 || !depthEmit || depthAddr != expAddr(8'hFF)) doneBad++;
      end
    end else begin
      prevPhase = 3'd0;
    end
  end

  // ---------------- driver ----------------
  task automatic rw(input logic [7:0] i, input logic [31:0] c, input logic [31:0] z);
    @(negedge clk);
    rastWe = 1'b1; rastIdx = i; rastC = c; rastZ = z;
    expC[i] = c; expZ[i] = z;
  endtask

  task automatic reset_check();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(phase == 3'd0 && !batchDone && !reloadStart && !tileColorWe && !tileDepthWe &&
          !colorEmit && !depthEmit, "R1 state during reset", 64'(phase), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(phase == 3'd0 && !batchDone && !colorEmit && !depthEmit && !tileColorWe,
          "R1 state after reset", 64'(phase), 64'd0);
  endtask

  task automatic run_batch(input int id, input bit reloads, input int rmode);
    @(posedge clk);
    cEm = 0; zEm = 0; clrSeen = 0; clrBad = 0; rlStarts = 0; rlNoReady = 0; doneBad = 0;
    traceQ.delete();
    readyMode = rmode;
    if (!reloads) for (int i = 0; i < 256; i++) begin expC[i] = CLR_C; expZ[i] = CLR_Z; end
    @(negedge clk);
    batchStart = 1'b1;
    @(negedge clk);
    batchStart = 1'b0;
    while (!renderEn) @(negedge clk);
    case (id)
      1: begin
        rw(8'h11, 32'hFF00_00FF, 32'h0000_8000);
        rw(8'hA2, 32'hFF12_3456, 32'h0000_7000);
        rw(8'hFF, 32'hFFAB_CDEF, 32'h0000_9000);
        rw(8'h00, 32'hFF00_0001, 32'h0000_5000);
      end
      2: begin
        rw(8'h2A, 32'hFFFF_0000, 32'h0000_6000);
        rw(8'hA2, 32'hFF65_4321, 32'h0000_7100);
      end
      4: rw(8'h80, 32'hFF0F_0F0F, 32'h0000_4400);
      default: ;
    endcase
    @(negedge clk);
    rastWe = 1'b0;
    for (int i = 0; i < 256; i++) begin
      colorQ.push_back({expAddr(8'(i)), expC[i]});
      depthQ.push_back({expAddr(8'(i)), expZ[i]});
    end
    if (id == 2) begin
      batchStart = 1'b1;              // R11: start pulse while busy
      @(negedge clk);
      batchStart = 1'b0;
      repeat (12) @(negedge clk);
      check(phase == 3'd2 && renderEn, "R6/R11 render held, start ignored", 64'(phase), 64'd2);
    end
    renderDone = 1'b1;
    @(negedge clk);
    renderDone = 1'b0;
    while (!batchDone) @(negedge clk);
    @(posedge clk);
    check(cEm == 256, "R7 color emit count", 64'(cEm), 64'd256);
    check(zEm == 256, "R8 depth emit count", 64'(zEm), 64'd256);
    check(clrSeen == 256 && clrBad == 0, "R3 clear writes", 64'(clrBad), 64'd0);
    check(rlStarts == (reloads ? 1 : 0), reloads ? "R5 one reload marker" : "R4 no reload marker",
          64'(rlStarts), reloads ? 64'd1 : 64'd0);
    check(rlNoReady == 0, "R5 reload write without ready", 64'(rlNoReady), 64'd0);
    check(doneBad == 0, "R10 done pulse timing", 64'(doneBad), 64'd0);
    if (reloads)
      check(traceQ.size() == 6 && traceQ[0] == 3'd1 && traceQ[1] == 3'd5 && traceQ[2] == 3'd2 &&
            traceQ[3] == 3'd3 && traceQ[4] == 3'd6 && traceQ[5] == 3'd0,
            "R2 phase order with reload", 64'(traceQ.size()), 64'd6);
    else
      check(traceQ.size() == 5 && traceQ[0] == 3'd1 && traceQ[1] == 3'd2 &&
            traceQ[2] == 3'd3 && traceQ[3] == 3'd6 && traceQ[4] == 3'd0,
            "R2/R4 phase order without reload", 64'(traceQ.size()), 64'd5);
    check(colorQ.size() == 0 && depthQ.size() == 0, "R7/R8 scoreboard drained",
          64'(colorQ.size() + depthQ.size()), 64'd0);
  endtask

  initial begin
    nCmp = 0; nBad = 0; cyc = 0; readyMode = 0;
    rstN = 1'b0; batchStart = 1'b0; renderDone = 1'b0;
    rastWe = 1'b0; rastIdx = '0; rastC = '0; rastZ = '0;
    reset_check();
    run_batch(1, 1'b0, 1);   // boot from clear
    run_batch(2, 1'b1, 1);   // reload with ready stalls
    run_batch(3, 1'b1, 0);   // reload with steady ready, no render writes
    reset_check();
    run_batch(4, 1'b0, 0);   // reset clears the batch-valid flag
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule